// File: doc/BRIEF.md
# Signed Over-Current Gate Guard

This block protects a three-phase power stage. Once per PWM period a conversion sequencer presents fresh signed current samples for phase A, phase C and the DC link, together with a one-cycle new-data strobe. On that strobe cycle every sample is compared against a symmetric magnitude limit. Phase A and phase C share the phase limit, and the DC channel has a limit of its own. A sample beyond its limit in either polarity trips the guard.

A trip forces all gate-drive enables low on the next clock edge and latches a fault. The fault holds until software or a supervisor asserts a clear while the currently presented samples are all inside their limits. A status word records which channel tripped first and in which polarity, so the cause is kept after the power stage has been shut down. While no fault is latched, the requested gate enables pass through a single register stage.

Top module: `ocp_guard`

## Requirements
- R1: While reset is high, every gate enable and every bit of the status word read 0 after each clock edge.
- R2: With no fault latched and no trip, `gate_en` equals the `gate_req` value presented one clock edge earlier.
- R3: A sample above its positive limit (sample > limit), presented on a strobe cycle, makes all `gate_en` bits 0 and sets status bit 3 (fault) from the next clock edge.
- R4: A sample below the negated limit (sample < -limit) on a strobe cycle trips in the same way and sets status bit 2 (polarity, 1 = negative).
- R5: A sample exactly equal to +limit or -limit does not trip.
- R6: Samples are compared only on cycles where `sample_vld` is 1. An out-of-range sample with `sample_vld` at 0 causes no trip.
- R7: Once latched, the fault and the whole status word hold, and `gate_en` stays 0 whatever `gate_req` is, until a clear is accepted. Later trips do not change the recorded channel or polarity.
- R8: Status bits [1:0] hold the channel that tripped: 00 = phase A, 01 = phase C, 10 = DC. Code 11 never appears.
- R9: If several channels trip on the same strobe, the recorded channel follows the priority phase A, then phase C, then DC.
- R10: `fault_clr` clears the fault, zeroes the status word and lets `gate_en` follow `gate_req` from the next edge, but only when all three presented samples are within their limits on that cycle. Otherwise the fault stays set, and a trip in that same cycle takes precedence over the clear.
- R11: The DC sample is compared against `lim_dc`. The phase samples are compared against `lim_phase`.
- R12: Samples are 12-bit two's complement and limits are 12-bit unsigned magnitudes. With a limit of 2047 the sample -2048 trips negative, and with a limit of 4095 no sample can trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | One-cycle strobe: fresh samples present |
| cur_a | input | 12 | Phase A current, two's complement |
| cur_c | input | 12 | Phase C current, two's complement |
| cur_dc | input | 12 | DC link current, two's complement |
| lim_phase | input | 12 | Unsigned magnitude limit for both phases |
| lim_dc | input | 12 | Unsigned magnitude limit for the DC channel |
| fault_clr | input | 1 | Request to release a latched fault |
| gate_req | input | 3 | Requested gate-drive enables |
| gate_en | output | 3 | Gated enables, registered |
| fault_word | output | 4 | Status: [3] fault, [2] negative polarity, [1:0] channel |

## Verification
Every result of this block is due one clock edge after the inputs that cause it. A trip on a strobe shows up as zero enables and a set fault bit after that same edge. Pass-through enables and an accepted clear also take effect on the edge that samples them. The driver applies each stimulus on a falling edge and pushes the expected enables and status for it. The monitor pops that item just after the following rising edge, so every comparison lands exactly one register stage after its stimulus.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int NUM_CH = 3;
  localparam int CH_W   = 2;
  localparam int STAT_W = CH_W + 2;
  localparam int IDX_A  = 0;
  localparam int IDX_C  = 1;
  localparam int IDX_DC = 2;

  typedef struct packed {
    logic             fault;
    logic             neg;
    logic [CH_W-1:0]  ch;
  } stat_t;
endpackage

// File: rtl/ocp_window.sv
module ocp_window #(
  parameter int SAMPLE_W = 12,
  parameter int LIM_W    = 12
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [LIM_W-1:0]    lim,
  output logic                       over_pos,
  output logic                       over_neg
);
  localparam int EW = ((SAMPLE_W > LIM_W) ? SAMPLE_W : LIM_W) + 2;

  logic signed [EW-1:0] s_x;
  logic signed [EW-1:0] l_x;
  logic signed [EW-1:0] l_neg;

  assign s_x      = {{(EW-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
  assign l_x      = {{(EW-LIM_W){1'b0}}, lim};
  assign l_neg    = -l_x;
  assign over_pos = (s_x > l_x);
  assign over_neg = (s_x < l_neg);
endmodule

// File: rtl/ocp_first.sv
module ocp_first
  import ocp_pkg::*;
(
  input  logic [NUM_CH-1:0] over_pos,
  input  logic [NUM_CH-1:0] over_neg,
  output logic              hit,
  output logic              hit_neg,
  output logic [CH_W-1:0]   hit_ch
);
  always_comb begin
    hit     = 1'b0;
    hit_neg = 1'b0;
    hit_ch  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (over_pos[i] || over_neg[i]) begin
        hit     = 1'b1;
        hit_neg = ~over_pos[i];
        hit_ch  = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/ocp_hold.sv
module ocp_hold
  import ocp_pkg::*;
#(
  parameter int GATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_vld,
  input  logic              hit,
  input  logic              hit_neg,
  input  logic [CH_W-1:0]   hit_ch,
  input  logic              fault_clr,
  input  logic [GATE_W-1:0] gate_req,
  output logic [GATE_W-1:0] gate_en,
  output stat_t             status
);
  logic trip;
  logic release_ok;
  logic fault_d;
  stat_t stat_q;
  logic [GATE_W-1:0] gate_q;

  assign trip       = sample_vld & hit;
  assign release_ok = fault_clr & ~hit;
  assign fault_d    = trip | (stat_q.fault & ~release_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      gate_q <= '0;
    end else begin
      gate_q <= fault_d ? '0 : gate_req;
      if (trip && !stat_q.fault) begin
        stat_q.fault <= 1'b1;
        stat_q.neg   <= hit_neg;
        stat_q.ch    <= hit_ch;
      end else if (stat_q.fault && !fault_d) begin
        stat_q <= '0;
      end
    end
  end

  assign gate_en = gate_q;
  assign status  = stat_q;
endmodule

// File: rtl/ocp_guard.sv
module ocp_guard
  import ocp_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LIM_W    = 12,
  parameter int GATE_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sample_vld,
  input  logic signed [SAMPLE_W-1:0] cur_a,
  input  logic signed [SAMPLE_W-1:0] cur_c,
  input  logic signed [SAMPLE_W-1:0] cur_dc,
  input  logic        [LIM_W-1:0]    lim_phase,
  input  logic        [LIM_W-1:0]    lim_dc,
  input  logic                       fault_clr,
  input  logic        [GATE_W-1:0]   gate_req,
  output logic        [GATE_W-1:0]   gate_en,
  output logic        [STAT_W-1:0]   fault_word
);
  logic signed [SAMPLE_W-1:0] smp [NUM_CH];
  logic [NUM_CH-1:0] over_pos;
  logic [NUM_CH-1:0] over_neg;
  logic              hit;
  logic              hit_neg;
  logic [CH_W-1:0]   hit_ch;
  stat_t             status;

  assign smp[IDX_A]  = cur_a;
  assign smp[IDX_C]  = cur_c;
  assign smp[IDX_DC] = cur_dc;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_win
    if (g == IDX_DC) begin : g_dc
      ocp_window #(.SAMPLE_W(SAMPLE_W), .LIM_W(LIM_W)) u_win (
        .sample  (smp[g]),
        .lim     (lim_dc),
        .over_pos(over_pos[g]),
        .over_neg(over_neg[g])
      );
    end else begin : g_ph
      ocp_window #(.SAMPLE_W(SAMPLE_W), .LIM_W(LIM_W)) u_win (
        .sample  (smp[g]),
        .lim     (lim_phase),
        .over_pos(over_pos[g]),
        .over_neg(over_neg[g])
      );
    end
  end

  ocp_first u_first (
    .over_pos(over_pos),
    .over_neg(over_neg),
    .hit     (hit),
    .hit_neg (hit_neg),
    .hit_ch  (hit_ch)
  );

  ocp_hold #(.GATE_W(GATE_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .sample_vld(sample_vld),
    .hit       (hit),
    .hit_neg   (hit_neg),
    .hit_ch    (hit_ch),
    .fault_clr (fault_clr),
    .gate_req  (gate_req),
    .gate_en   (gate_en),
    .status    (status)
  );

  assign fault_word = status;
endmodule

// File: rtl/ocp_guard_chk.sv
module ocp_guard_chk #(
  parameter int SAMPLE_W = 12,
  parameter int LIM_W    = 12,
  parameter int GATE_W   = 3
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       sample_vld,
  input logic signed [SAMPLE_W-1:0] cur_a,
  input logic signed [SAMPLE_W-1:0] cur_c,
  input logic signed [SAMPLE_W-1:0] cur_dc,
  input logic        [LIM_W-1:0]    lim_phase,
  input logic        [LIM_W-1:0]    lim_dc,
  input logic                       fault_clr,
  input logic        [GATE_W-1:0]   gate_req,
  input logic        [GATE_W-1:0]   gate_en,
  input logic        [3:0]          fault_word
);
  localparam int EW = ((SAMPLE_W > LIM_W) ? SAMPLE_W : LIM_W) + 2;

  logic signed [EW-1:0] ax, cx, dx, lp, ld;
  logic any_over;

  assign ax = EW'(cur_a);
  assign cx = EW'(cur_c);
  assign dx = EW'(cur_dc);
  assign lp = {{(EW-LIM_W){1'b0}}, lim_phase};
  assign ld = {{(EW-LIM_W){1'b0}}, lim_dc};
  assign any_over = (ax > lp) || (ax < -lp) || (cx > lp) || (cx < -lp) ||
                    (dx > ld) || (dx < -ld);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (gate_en == '0 && fault_word == '0));

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (!fault_word[3] && !sample_vld) |=> (gate_en == $past(gate_req)));

  // R3
  trip_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_vld && any_over) |=> (gate_en == '0 && fault_word[3]));

  // R6
  idle_no_trip_chk: assert property (@(posedge clk) disable iff (rst)
    (!sample_vld && !fault_word[3]) |=> !fault_word[3]);

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_word[3] && !fault_clr) |=> $stable(fault_word));

  // R7
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    fault_word[3] |-> (gate_en == '0));

  // R8
  chan_code_chk: assert property (@(posedge clk) disable iff (rst)
    fault_word[3] |-> (fault_word[1:0] != 2'b11));

  // R10
  clear_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_word[3] && fault_clr && !any_over) |=> (fault_word == '0));

  // R10
  clear_block_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_word[3] && any_over) |=> fault_word[3]);
endmodule

bind ocp_guard ocp_guard_chk #(
  .SAMPLE_W(SAMPLE_W), .LIM_W(LIM_W), .GATE_W(GATE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sample_vld(sample_vld),
  .cur_a     (cur_a),
  .cur_c     (cur_c),
  .cur_dc    (cur_dc),
  .lim_phase (lim_phase),
  .lim_dc    (lim_dc),
  .fault_clr (fault_clr),
  .gate_req  (gate_req),
  .gate_en   (gate_en),
  .fault_word(fault_word)
);

// File: tb/sim_ocp_guard.sv
`timescale 1ns/1ps
module sim_ocp_guard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_vld = 1'b0;
  logic signed [11:0] cur_a = '0, cur_c = '0, cur_dc = '0;
  logic [11:0] lim_phase = 12'd500, lim_dc = 12'd1000;
  logic fault_clr = 1'b0;
  logic [2:0] gate_req = '0;
  logic [2:0] gate_en;
  logic [3:0] fault_word;

  always #2.5 clk = ~clk;

  ocp_guard u0 (
    .clk(clk), .rst(rst), .sample_vld(sample_vld),
    .cur_a(cur_a), .cur_c(cur_c), .cur_dc(cur_dc),
    .lim_phase(lim_phase), .lim_dc(lim_dc), .fault_clr(fault_clr),
    .gate_req(gate_req), .gate_en(gate_en), .fault_word(fault_word)
  );

  typedef struct {
    logic [2:0] gate;
    logic [3:0] word;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit m_fault = 0;
  bit m_neg = 0;
  logic [1:0] m_ch = 2'b00;

  function automatic bit beyond_pos(logic signed [11:0] s, logic [11:0] l);
    int si = s;
    int li = l;
    return si > li;
  endfunction

  function automatic bit beyond_neg(logic signed [11:0] s, logic [11:0] l);
    int si = s;
    int li = l;
    return si < -li;
  endfunction

  task automatic step(input logic signed [11:0] a, input logic signed [11:0] c,
                      input logic signed [11:0] dc, input logic v, input logic clr,
                      input logic [2:0] req, input string tag);
    bit pa, na, pc, nc, pd, nd, any;
    exp_t e;
    @(negedge clk);
    cur_a = a; cur_c = c; cur_dc = dc;
    sample_vld = v; fault_clr = clr; gate_req = req;
    pa = beyond_pos(a, lim_phase);  na = beyond_neg(a, lim_phase);
    pc = beyond_pos(c, lim_phase);  nc = beyond_neg(c, lim_phase);
    pd = beyond_pos(dc, lim_dc);    nd = beyond_neg(dc, lim_dc);
    any = pa | na | pc | nc | pd | nd;
    if (v && any) begin
      if (!m_fault) begin
        m_fault = 1;
        if (pa | na)      begin m_ch = 2'b00; m_neg = na; end
        else if (pc | nc) begin m_ch = 2'b01; m_neg = nc; end
        else              begin m_ch = 2'b10; m_neg = nd; end
      end
    end else if (clr && !any && m_fault) begin
      m_fault = 0; m_neg = 0; m_ch = 2'b00;
    end
    e.gate = m_fault ? 3'b000 : req;
    e.word = {m_fault, m_neg, m_ch};
    e.tag  = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (gate_en !== e.gate || fault_word !== e.word) begin
          errors++;
          $display("FAIL %s: gate_en=%b fault_word=%b expected gate_en=%b fault_word=%b",
                   e.tag, gate_en, fault_word, e.gate, e.word);
        end
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin : driver
    // R1: reset state with requests asserted
    gate_req = 3'b111;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (gate_en !== 3'b000 || fault_word !== 4'b0000) begin
      errors++;
      $display("FAIL R1: gate_en=%b fault_word=%b expected 000 0000", gate_en, fault_word);
    end
    rst = 1'b0;

    // R2: pass-through under several patterns
    step(12'sd0,   12'sd0,    12'sd0,   1, 0, 3'b101, "R2");
    step(12'sd100, -12'sd200, 12'sd300, 1, 0, 3'b010, "R2");
    step(12'sd0,   12'sd0,    12'sd0,   0, 0, 3'b111, "R2");
    // R5: exactly at the limits
    step(12'sd500, -12'sd500, 12'sd1000, 1, 0, 3'b111, "R5");
    step(-12'sd500, 12'sd500, -12'sd1000, 1, 0, 3'b011, "R5");
    // R6: out of range without strobe
    step(12'sd2000, -12'sd2000, 12'sd2000, 0, 0, 3'b110, "R6");
    // R3: positive trip on phase A
    step(12'sd501, 12'sd0, 12'sd0, 1, 0, 3'b111, "R3");
    // R7: latched; later DC trip does not change record
    step(12'sd0, 12'sd0, -12'sd1500, 1, 0, 3'b111, "R7");
    step(12'sd0, 12'sd0, 12'sd0, 0, 0, 3'b111, "R7");
    // R10: clear refused while a present sample is out of range
    step(12'sd600, 12'sd0, 12'sd0, 0, 1, 3'b111, "R10");
    // R10: clear accepted
    step(12'sd0, 12'sd0, 12'sd0, 0, 1, 3'b101, "R10");
    step(12'sd0, 12'sd0, 12'sd0, 0, 0, 3'b011, "R10");
    // R4/R8: negative trip on phase C
    step(12'sd0, -12'sd501, 12'sd0, 1, 0, 3'b111, "R4");
    step(12'sd0, 12'sd0, 12'sd0, 0, 1, 3'b111, "R10");
    // R11: DC has its own limit
    step(12'sd0, 12'sd0, 12'sd800, 1, 0, 3'b111, "R11");
    step(12'sd0, 12'sd0, 12'sd1001, 1, 0, 3'b111, "R11");
    step(12'sd0, 12'sd0, 12'sd0, 0, 1, 3'b111, "R8");
    // R9: simultaneous trips, priority A > C > DC
    step(-12'sd900, 12'sd900, 12'sd1200, 1, 0, 3'b111, "R9");
    step(12'sd0, 12'sd0, 12'sd0, 0, 1, 3'b111, "R9");
    step(12'sd0, 12'sd700, -12'sd1200, 1, 0, 3'b111, "R9");
    // R10: trip wins over clear in the same cycle
    step(12'sd0, 12'sd0, 12'sd0, 0, 1, 3'b111, "R10");
    step(12'sd0, 12'sd0, 12'sd1100, 1, 1, 3'b111, "R10");
    step(12'sd0, 12'sd0, 12'sd0, 0, 1, 3'b111, "R10");
    // R12: extreme codes
    @(negedge clk);
    lim_phase = 12'd2047;
    step(-12'sd2048, 12'sd0, 12'sd0, 1, 0, 3'b111, "R12");
    step(12'sd0, 12'sd0, 12'sd0, 0, 1, 3'b111, "R12");
    @(negedge clk);
    lim_phase = 12'd4095;
    lim_dc = 12'd4095;
    step(-12'sd2048, 12'sd2047, -12'sd2048, 1, 0, 3'b111, "R12");
    step(12'sd2047, -12'sd2048, 12'sd2047, 1, 0, 3'b010, "R12");

    repeat (4) @(posedge clk);
    #2;
    done = 1;
    summary();
    $finish;
  end
endmodule